// File: doc/BRIEF.md
# Hash-Indexed Bucket Search Engine

This block looks up a search key in a table that is held in plain RAM, not in a content-addressable array. The RAM is organised as buckets, and each bucket row holds a fixed number of slots. Each slot carries a valid flag, a key and a short data word. A search key is folded down to a row number, and only that row is read out. Every slot of the fetched row is then compared with the key in the same cycle. The matching slot with the smallest index is reported together with its stored data. Table software keeps the entries of a row in preference order, so the smallest index is the preferred one, for example the longest prefix. Because the data sits beside the key, no second read is needed.

Searches arrive on a valid/ready stream and pass through four register stages: row-number generation, row read, slot matching, and result selection. A new search can enter on every cycle. Results leave on a valid/ready stream in the order the searches were accepted. When the result consumer holds `res_ready` low while a result is waiting, the whole pipeline freezes. The result stays on the port unchanged and `srch_ready` falls, so back-pressure reaches the producer in the same cycle. Table contents are loaded one slot at a time through a plain write strobe, with no handshake.

Top module: `hashrow_lookup`

## Requirements
- R1: After reset, `res_valid` is 0, `srch_ready` is 1, and every slot is empty, so any search misses.
- R2: The row number is the XOR of the consecutive 4-bit groups of the top 16 key bits: key[31:28]^key[27:24]^key[23:20]^key[19:16] for the default 16 rows. A key stored in any other row never hits.
- R3: A search whose key equals the key of a valid slot in its row returns `res_hit`=1, that slot's index on `res_slot` and that slot's data on `res_data`. This holds for every slot position, the last one included.
- R4: When several valid slots of the row hold the search key, the slot with the lowest index is returned.
- R5: A slot written with `wr_live`=0 never matches, even if its key equals the search key.
- R6: A miss returns `res_hit`=0, `res_slot`=0 and `res_data`=0, whatever data the row holds.
- R7: With `res_ready` held at 1, a search accepted at clock edge N is presented on the result port just after edge N+3. Searches accepted on consecutive edges give results on consecutive cycles, in the same order.
- R8: While `res_valid`=1 and `res_ready`=0, the result fields stay stable and `srch_ready` is 0. No accepted search is lost or reordered once the stall ends.
- R9: A slot write is seen by searches accepted on the same edge as the write or later. It is not seen by searches accepted on earlier edges.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| srch_valid | input | 1 | Search request valid |
| srch_ready | output | 1 | Search request accepted when high together with `srch_valid` |
| srch_key | input | 32 | Search key |
| res_valid | output | 1 | Result valid |
| res_ready | input | 1 | Consumer takes the result when high |
| res_hit | output | 1 | 1 when a slot matched |
| res_slot | output | 3 | Index of the winning slot; 0 on a miss |
| res_data | output | 8 | Data of the winning slot; 0 on a miss |
| wr_en | input | 1 | Write one slot on this edge |
| wr_row | input | 4 | Row to write |
| wr_slot | input | 3 | Slot within the row to write |
| wr_live | input | 1 | Valid flag stored with the slot |
| wr_key | input | 32 | Key stored in the slot |
| wr_data | input | 8 | Data stored in the slot |

## Verification
The lookup is tried with keys whose low 16 bits agree but whose top bits send them to different rows, and with a key that the XOR fold sends to a row its raw top nibble does not name. Together these separate true row folding from plain bit selection. Rows holding duplicate keys, first both valid and then with the lower slot cleared, show that the lowest valid slot wins and that cleared slots are ignored. A back-to-back stream and a stalled stream show exact latency, ordering, and that nothing is dropped. A search issued in the cycle before a write, and another issued in the same cycle as the write, tell old row contents from new ones.

// File: rtl/hrl_pkg.sv
`timescale 1ns/1ps
package hrl_pkg;
  // number of leading key bits that feed the row-number fold
  localparam int HASH_SRC_W = 16;
  // fixed register stages between request and result
  localparam int PIPE_DEPTH = 4;
endpackage

// File: rtl/hrl_index_gen.sv
`timescale 1ns/1ps
module hrl_index_gen
  import hrl_pkg::*;
#(
  parameter int IDX_W = 4
) (
  input  logic [HASH_SRC_W-1:0] src,
  output logic [IDX_W-1:0]      row
);
  localparam int N_CHUNK = (HASH_SRC_W + IDX_W - 1) / IDX_W;
  localparam int PAD_W   = N_CHUNK * IDX_W;

  logic [PAD_W-1:0] padded;
  assign padded = PAD_W'(src);

  // XOR-fold the leading key bits into a row number
  always_comb begin
    row = '0;
    for (int c = 0; c < N_CHUNK; c++) row = row ^ padded[c*IDX_W +: IDX_W];
  end
endmodule

// File: rtl/hrl_bucket_ram.sv
`timescale 1ns/1ps
module hrl_bucket_ram #(
  parameter int ROWS   = 16,
  parameter int SLOTS  = 8,
  parameter int KEY_W  = 32,
  parameter int DATA_W = 8,
  parameter int IDX_W  = 4,
  parameter int SLOT_W = 3
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic                          wr_en,
  input  logic [IDX_W-1:0]              wr_row,
  input  logic [SLOT_W-1:0]             wr_slot,
  input  logic                          wr_live,
  input  logic [KEY_W-1:0]              wr_key,
  input  logic [DATA_W-1:0]             wr_data,
  input  logic                          rd_en,
  input  logic [IDX_W-1:0]              rd_row,
  output logic [SLOTS-1:0]              rd_live,
  output logic [SLOTS-1:0][KEY_W-1:0]   rd_key,
  output logic [SLOTS-1:0][DATA_W-1:0]  rd_data
);
  logic [ROWS-1:0][SLOTS-1:0] live_mem;
  logic [KEY_W-1:0]           key_mem  [ROWS][SLOTS];
  logic [DATA_W-1:0]          data_mem [ROWS][SLOTS];

  // valid flags are the only state cleared by reset
  always_ff @(posedge clk) begin
    if (rst) begin
      live_mem <= '0;
      rd_live  <= '0;
    end else begin
      if (wr_en) live_mem[wr_row][wr_slot] <= wr_live;
      if (rd_en) rd_live <= live_mem[rd_row];
    end
  end

  always_ff @(posedge clk) begin
    if (wr_en) begin
      key_mem[wr_row][wr_slot]  <= wr_key;
      data_mem[wr_row][wr_slot] <= wr_data;
    end
  end

  // one registered row read; a same-edge write is not forwarded
  always_ff @(posedge clk) begin
    if (rd_en) begin
      for (int s = 0; s < SLOTS; s++) begin
        rd_key[s]  <= key_mem[rd_row][s];
        rd_data[s] <= data_mem[rd_row][s];
      end
    end
  end
endmodule

// File: rtl/hrl_match.sv
`timescale 1ns/1ps
module hrl_match #(
  parameter int SLOTS = 8,
  parameter int KEY_W = 32
) (
  input  logic [KEY_W-1:0]             key,
  input  logic [SLOTS-1:0]             slot_live,
  input  logic [SLOTS-1:0][KEY_W-1:0]  slot_key,
  output logic [SLOTS-1:0]             hit_vec
);
  // broadcast the search key to one comparator per slot
  logic [SLOTS-1:0][KEY_W-1:0] key_bcast;
  assign key_bcast = {SLOTS{key}};

  for (genvar s = 0; s < SLOTS; s++) begin : g_cmp
    assign hit_vec[s] = slot_live[s] && (slot_key[s] == key_bcast[s]);
  end
endmodule

// File: rtl/hrl_priority.sv
`timescale 1ns/1ps
module hrl_priority #(
  parameter int SLOTS  = 8,
  parameter int SLOT_W = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [SLOTS-1:0]  hit_vec,
  output logic              any_hit,
  output logic [SLOT_W-1:0] win
);
  // scan from the top so the lowest set bit is written last
  always_comb begin
    any_hit = |hit_vec;
    win     = '0;
    for (int s = SLOTS - 1; s >= 0; s--) begin
      if (hit_vec[s]) win = SLOT_W'(s);
    end
  end

  logic [SLOTS-1:0] below_win;
  assign below_win = (SLOTS'(1) << win) - SLOTS'(1);

  // R4: the chosen slot matched and no lower slot did
  assert_lowest_slot_wins_R4: assert property (@(posedge clk) disable iff (rst)
    any_hit |-> (hit_vec[win] && ((hit_vec & below_win) == '0)));
endmodule

// File: rtl/hashrow_lookup.sv
`timescale 1ns/1ps
module hashrow_lookup
  import hrl_pkg::*;
#(
  parameter int ROWS   = 16,
  parameter int SLOTS  = 8,
  parameter int KEY_W  = 32,
  parameter int DATA_W = 8,
  localparam int IDX_W  = $clog2(ROWS),
  localparam int SLOT_W = $clog2(SLOTS)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              srch_valid,
  output logic              srch_ready,
  input  logic [KEY_W-1:0]  srch_key,
  output logic              res_valid,
  input  logic              res_ready,
  output logic              res_hit,
  output logic [SLOT_W-1:0] res_slot,
  output logic [DATA_W-1:0] res_data,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_row,
  input  logic [SLOT_W-1:0] wr_slot,
  input  logic              wr_live,
  input  logic [KEY_W-1:0]  wr_key,
  input  logic [DATA_W-1:0] wr_data
);
  localparam int CNT_W = $clog2(PIPE_DEPTH + 1);

  // whole pipeline moves only when the result register can be refilled
  logic adv;
  assign adv        = !res_valid || res_ready;
  assign srch_ready = adv;

  // stage 1: row-number generation
  logic [IDX_W-1:0] row_c;
  logic             s1_valid;
  logic [KEY_W-1:0] s1_key;
  logic [IDX_W-1:0] s1_row;

  hrl_index_gen #(.IDX_W(IDX_W)) u_index (
    .src (srch_key[KEY_W-1 -: HASH_SRC_W]),
    .row (row_c)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      s1_valid <= 1'b0;
      s1_key   <= '0;
      s1_row   <= '0;
    end else if (adv) begin
      s1_valid <= srch_valid;
      s1_key   <= srch_key;
      s1_row   <= row_c;
    end
  end

  // stage 2: bucket row read
  logic                         s2_valid;
  logic [KEY_W-1:0]             s2_key;
  logic [SLOTS-1:0]             s2_live;
  logic [SLOTS-1:0][KEY_W-1:0]  s2_keys;
  logic [SLOTS-1:0][DATA_W-1:0] s2_data;

  hrl_bucket_ram #(
    .ROWS(ROWS), .SLOTS(SLOTS), .KEY_W(KEY_W), .DATA_W(DATA_W),
    .IDX_W(IDX_W), .SLOT_W(SLOT_W)
  ) u_ram (
    .clk     (clk),
    .rst     (rst),
    .wr_en   (wr_en),
    .wr_row  (wr_row),
    .wr_slot (wr_slot),
    .wr_live (wr_live),
    .wr_key  (wr_key),
    .wr_data (wr_data),
    .rd_en   (adv),
    .rd_row  (s1_row),
    .rd_live (s2_live),
    .rd_key  (s2_keys),
    .rd_data (s2_data)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      s2_valid <= 1'b0;
      s2_key   <= '0;
    end else if (adv) begin
      s2_valid <= s1_valid;
      s2_key   <= s1_key;
    end
  end

  // stage 3: parallel slot compare
  logic [SLOTS-1:0]             hit_vec_c;
  logic                         s3_valid;
  logic [SLOTS-1:0]             s3_hits;
  logic [SLOTS-1:0][DATA_W-1:0] s3_data;

  hrl_match #(.SLOTS(SLOTS), .KEY_W(KEY_W)) u_match (
    .key       (s2_key),
    .slot_live (s2_live),
    .slot_key  (s2_keys),
    .hit_vec   (hit_vec_c)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      s3_valid <= 1'b0;
      s3_hits  <= '0;
      s3_data  <= '0;
    end else if (adv) begin
      s3_valid <= s2_valid;
      s3_hits  <= hit_vec_c;
      s3_data  <= s2_data;
    end
  end

  // stage 4: priority pick and result forwarding
  logic              pick_hit;
  logic [SLOT_W-1:0] pick_slot;

  hrl_priority #(.SLOTS(SLOTS), .SLOT_W(SLOT_W)) u_pick (
    .clk     (clk),
    .rst     (rst),
    .hit_vec (s3_hits),
    .any_hit (pick_hit),
    .win     (pick_slot)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      res_valid <= 1'b0;
      res_hit   <= 1'b0;
      res_slot  <= '0;
      res_data  <= '0;
    end else if (adv) begin
      res_valid <= s3_valid;
      res_hit   <= pick_hit;
      res_slot  <= pick_hit ? pick_slot : '0;
      res_data  <= pick_hit ? s3_data[pick_slot] : '0;
    end
  end

  // checker: searches accepted but not yet delivered
  logic [CNT_W-1:0] inflight;
  always_ff @(posedge clk) begin
    if (rst) inflight <= '0;
    else inflight <= inflight + CNT_W'(srch_valid && srch_ready)
                              - CNT_W'(res_valid && res_ready);
  end

  assert_reset_idle_R1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> !res_valid);

  assert_miss_clears_R6: assert property (@(posedge clk) disable iff (rst)
    (res_valid && !res_hit) |-> (res_slot == '0 && res_data == '0));

  assert_pipe_depth_R7: assert property (@(posedge clk) disable iff (rst)
    inflight <= CNT_W'(PIPE_DEPTH));

  assert_result_has_source_R7: assert property (@(posedge clk) disable iff (rst)
    res_valid |-> inflight != '0);

  assert_hold_on_stall_R8: assert property (@(posedge clk) disable iff (rst)
    (res_valid && !res_ready) |=> (res_valid && $stable(res_hit)
                                   && $stable(res_slot) && $stable(res_data)));
endmodule

// File: tb/test_hashrow_lookup.sv
`timescale 1ns/1ps
module test_hashrow_lookup;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        srch_valid = 1'b0;
  logic        srch_ready;
  logic [31:0] srch_key = '0;
  logic        res_valid;
  logic        res_ready = 1'b1;
  logic        res_hit;
  logic [2:0]  res_slot;
  logic [7:0]  res_data;
  logic        wr_en = 1'b0;
  logic [3:0]  wr_row = '0;
  logic [2:0]  wr_slot = '0;
  logic        wr_live = 1'b0;
  logic [31:0] wr_key = '0;
  logic [7:0]  wr_data = '0;

  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  hashrow_lookup i_hashrow_lookup (
    .clk(clk), .rst(rst),
    .srch_valid(srch_valid), .srch_ready(srch_ready), .srch_key(srch_key),
    .res_valid(res_valid), .res_ready(res_ready), .res_hit(res_hit),
    .res_slot(res_slot), .res_data(res_data),
    .wr_en(wr_en), .wr_row(wr_row), .wr_slot(wr_slot), .wr_live(wr_live),
    .wr_key(wr_key), .wr_data(wr_data)
  );

  task automatic chk(input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // result port compared as {valid, hit, slot, data}
  task automatic chk_out(input string req, input bit eh, input int es,
                         input logic [7:0] ed);
    chk(req, "result {valid,hit,slot,data}",
        {res_valid, res_hit, res_slot, res_data},
        {1'b1, eh, es[2:0], ed});
  endtask

  task automatic put(input int row, input int slot, input bit live,
                     input logic [31:0] key, input logic [7:0] data);
    @(negedge clk);
    wr_en = 1'b1; wr_row = row[3:0]; wr_slot = slot[2:0];
    wr_live = live; wr_key = key; wr_data = data;
    @(posedge clk);
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  // accept on one edge, sample just after the third edge that follows
  task automatic expect_lookup(input string req, input logic [31:0] key,
                               input bit eh, input int es, input logic [7:0] ed);
    @(negedge clk);
    srch_valid = 1'b1; srch_key = key;
    @(posedge clk);
    @(negedge clk);
    srch_valid = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk_out(req, eh, es, ed);
  endtask

  task automatic t_reset();
    chk("R1", "res_valid after reset", res_valid, 0);
    chk("R1", "srch_ready after reset", srch_ready, 1);
    expect_lookup("R1", 32'h0000_0000, 0, 0, 8'h00);
  endtask

  task automatic t_hit_and_rows();
    put(3, 2, 1, 32'h3000_ABCD, 8'h5A);
    expect_lookup("R3", 32'h3000_ABCD, 1, 2, 8'h5A);
    expect_lookup("R2", 32'h5000_ABCD, 0, 0, 8'h00);
    put(5, 0, 1, 32'h3000_1234, 8'h77);
    expect_lookup("R2", 32'h3000_1234, 0, 0, 8'h00);
    put(3, 5, 1, 32'h1200_0000, 8'h3C);
    expect_lookup("R2", 32'h1200_0000, 1, 5, 8'h3C);
    put(3, 7, 1, 32'h3000_FFFF, 8'hE1);
    expect_lookup("R3", 32'h3000_FFFF, 1, 7, 8'hE1);
  endtask

  task automatic t_priority();
    put(7, 0, 1, 32'h7000_0041, 8'h99);
    put(7, 1, 1, 32'h7000_0042, 8'h11);
    put(7, 4, 1, 32'h7000_0042, 8'h44);
    expect_lookup("R4", 32'h7000_0042, 1, 1, 8'h11);
    put(7, 1, 0, 32'h7000_0042, 8'h11);
    expect_lookup("R5", 32'h7000_0042, 1, 4, 8'h44);
    put(7, 4, 0, 32'h7000_0042, 8'h44);
    expect_lookup("R5", 32'h7000_0042, 0, 0, 8'h00);
  endtask

  task automatic t_miss();
    put(9, 0, 1, 32'h9000_0001, 8'hFF);
    expect_lookup("R6", 32'h9000_0002, 0, 0, 8'h00);
    expect_lookup("R3", 32'h9000_0001, 1, 0, 8'hFF);
  endtask

  task automatic t_stream();
    logic [31:0] keys [4] = '{32'h3000_ABCD, 32'h5000_ABCD, 32'h1200_0000, 32'h3000_FFFF};
    bit          hits [4] = '{1, 0, 1, 1};
    int          slots [4] = '{2, 0, 5, 7};
    logic [7:0]  datas [4] = '{8'h5A, 8'h00, 8'h3C, 8'hE1};
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      srch_valid = 1'b1; srch_key = keys[i];
      if (i == 3) chk("R7", "no result before fourth edge", res_valid, 0);
      @(posedge clk);
    end
    @(negedge clk);
    srch_valid = 1'b0;
    chk_out("R7", hits[0], slots[0], datas[0]);
    for (int i = 1; i < 4; i++) begin
      @(negedge clk);
      chk_out("R7", hits[i], slots[i], datas[i]);
    end
    @(negedge clk);
    chk("R7", "stream drained", res_valid, 0);
  endtask

  task automatic t_backpressure();
    logic [31:0] keys [5] = '{32'h3000_ABCD, 32'h1200_0000, 32'h5000_ABCD,
                              32'h3000_FFFF, 32'h9000_0001};
    bit          hits [5] = '{1, 1, 0, 1, 1};
    int          slots [5] = '{2, 5, 0, 7, 0};
    logic [7:0]  datas [5] = '{8'h5A, 8'h3C, 8'h00, 8'hE1, 8'hFF};
    @(negedge clk);
    res_ready = 1'b0;
    for (int i = 0; i < 4; i++) begin
      if (i > 0) @(negedge clk);
      srch_valid = 1'b1; srch_key = keys[i];
      @(posedge clk);
    end
    @(negedge clk);
    srch_key = keys[4];
    chk_out("R8", hits[0], slots[0], datas[0]);
    chk("R8", "srch_ready while stalled", srch_ready, 0);
    repeat (3) begin
      @(posedge clk);
      @(negedge clk);
    end
    chk_out("R8", hits[0], slots[0], datas[0]);
    chk("R8", "srch_ready still stalled", srch_ready, 0);
    res_ready = 1'b1;
    @(posedge clk);
    @(negedge clk);
    srch_valid = 1'b0;
    chk_out("R8", hits[1], slots[1], datas[1]);
    for (int i = 2; i < 5; i++) begin
      @(negedge clk);
      chk_out("R8", hits[i], slots[i], datas[i]);
    end
    @(negedge clk);
    chk("R8", "drained after stall", res_valid, 0);
  endtask

  task automatic t_write_order();
    put(11, 3, 1, 32'hB000_0007, 8'h11);
    @(negedge clk);
    srch_valid = 1'b1; srch_key = 32'hB000_0007;
    @(posedge clk);
    @(negedge clk);
    wr_en = 1'b1; wr_row = 4'd11; wr_slot = 3'd3; wr_live = 1'b1;
    wr_key = 32'hB000_0007; wr_data = 8'h22;
    @(posedge clk);
    @(negedge clk);
    srch_valid = 1'b0; wr_en = 1'b0;
    repeat (2) @(posedge clk);
    @(negedge clk);
    chk_out("R9", 1, 3, 8'h11);
    @(negedge clk);
    chk_out("R9", 1, 3, 8'h22);
  endtask

  task automatic finish_run();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_hit_and_rows();
    t_priority();
    t_miss();
    t_stream();
    t_backpressure();
    t_write_order();
    finish_run();
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual running expected finished");
    finish_run();
  end
endmodule